// File: doc/BRIEF.md
# Dual-Mode Capture/Compare Timer Channel

This block is one timer channel made of a free-running 16-bit counter and one 16-bit general register whose role is picked by a 3-bit mode field. In the compare half of the code space the register is a match value: when the counter reaches it, the channel pin output is forced low, forced high or inverted. In the capture half it is a snapshot register: selected edges on the timer pin input, after a two-flop synchronizer, copy the counter into it. While it captures, software cannot overwrite it.

A small synchronous register bus reaches the mode register, the general register, a sticky status register and the counter. The status register keeps separate capture, match and wrap flags. Software clears a flag by writing 0 to a bit that currently reads 1.

Top module: `cc_timer_channel`

## Requirements
- R1: After reset the mode register (address 0), the general register (address 1) and the status register (address 2) read 0, and the pin output is 0.
- R2: The counter (address 3) increments by one each clock, and a bus write to address 3 loads it instead. When it steps from 0xFFFF to 0x0000, status bit 2 (wrap) is set on that same edge.
- R3: A match occurs in any cycle in which mode is 1, 2 or 3 and the counter equals the general register. The pin change and status bit 1 (match) take effect on the following clock edge.
- R4: On a match, mode 1 drives the pin output low, mode 2 drives it high and mode 3 inverts it.
- R5: In mode 0 and in modes 4 to 7, no match occurs: the pin output keeps its last value and status bit 1 is not set.
- R6: Mode 5 captures on a rising pin edge, mode 6 on a falling edge and mode 7 on both. The captured value is the counter value two clock edges after the pin changes, because of the synchronizer. Each capture sets status bit 0.
- R7: Mode 4 performs no capture. Pin edges leave the general register and status bit 0 unchanged.
- R8: Bus writes to the general register are ignored in modes 5 to 7 and take effect in modes 0 to 4.
- R9: Mode register bits 2:0 hold the mode. Bit 3 and all higher bits read 0 whatever was written.
- R10: Writing 0 to a status bit that reads 1 clears it. Writing 1 leaves the bit unchanged.
- R11: If a flag's event and a clearing write fall on the same edge, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 mode, 1 general, 2 status, 3 counter |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tmr_pin_i | input | 1 | Timer pin input (asynchronous) |
| tmr_pin_o | output | 1 | Timer pin output |

## Verification
The compare path is tried with the counter preset three counts below the match value in each of the drive-low, drive-high and invert modes. The pin is sampled just before and just after the match edge, which tells the one-cycle action latency apart from a zero- or two-cycle one. The capture path is driven with single rising and falling pin edges in each capture mode, with the counter preset to a known value. Each captured value then shows both the edge selection and the exact synchronizer delay. Writes to the general register are repeated in disabled and capture modes, and a flag clear is placed on the exact edge of a match.

// File: rtl/cct_pkg.sv
package cct_pkg;

   typedef enum logic [2:0] {
      IO_OFF  = 3'd0,
      IO_CLR  = 3'd1,
      IO_SET  = 3'd2,
      IO_TGL  = 3'd3,
      IC_OFF  = 3'd4,
      IC_RISE = 3'd5,
      IC_FALL = 3'd6,
      IC_BOTH = 3'd7
   } io_mode_e;

   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_GREG = 2'd1;
   localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
   localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;

   localparam int ST_CAP    = 0;
   localparam int ST_CMP    = 1;
   localparam int ST_OVF    = 2;
   localparam int NUM_FLAGS = 3;
   localparam int MODE_W    = 3;

   function automatic logic is_cap_mode(input io_mode_e m);
      return m[2] && (m[1:0] != 2'b00);
   endfunction

   function automatic logic is_cmp_mode(input io_mode_e m);
      return !m[2] && (m[1:0] != 2'b00);
   endfunction

endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   // sh[0..STAGES-1] synchronize, sh[STAGES] holds previous synced value
   logic [STAGES:0] sh;

   generate
      for (genvar i = 0; i <= STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[0] <= 1'b0;
               else        sh[0] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= sh[i-1];
            end
         end
      end
   endgenerate

   assign rise_o =  sh[STAGES-1] & ~sh[STAGES];
   assign fall_o = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_o <= '0;
      else if (ld_en) cnt_o <= ld_val;
      else            cnt_o <= cnt_o + 1'b1;
   end

   assign wrap_o = (cnt_o == CNT_MAX) && !ld_en;
endmodule

// File: rtl/cct_cmp_cap.sv
module cct_cmp_cap
   import cct_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  io_mode_e         mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic             gr_we,
   input  logic [CNT_W-1:0] gr_wdata,
   input  logic             rise,
   input  logic             fall,
   output logic [CNT_W-1:0] gr_o,
   output logic             pin_o,
   output logic             cmp_evt_o,
   output logic             cap_evt_o
);
   logic cap_sel;

   always_comb begin
      unique case (mode)
         IC_RISE: cap_sel = rise;
         IC_FALL: cap_sel = fall;
         IC_BOTH: cap_sel = rise | fall;
         default: cap_sel = 1'b0;
      endcase
   end

   assign cap_evt_o = cap_sel;
   assign cmp_evt_o = is_cmp_mode(mode) && (cnt == gr_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           gr_o <= '0;
      else if (cap_sel)                     gr_o <= cnt;
      else if (gr_we && !is_cap_mode(mode)) gr_o <= gr_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_o <= 1'b0;
      end else if (cmp_evt_o) begin
         unique case (mode)
            IO_CLR:  pin_o <= 1'b0;
            IO_SET:  pin_o <= 1'b1;
            IO_TGL:  pin_o <= ~pin_o;
            default: pin_o <= pin_o;
         endcase
      end
   end
endmodule

// File: rtl/cc_timer_channel.sv
module cc_timer_channel
   import cct_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              tmr_pin_i,
   output logic              tmr_pin_o
);
   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("cc_timer_channel: CNT_W must be at least 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cc_timer_channel: SYNC_STAGES must be at least 2");
      end
   endgenerate

   io_mode_e             ctrl_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [CNT_W-1:0]     gr_q;
   logic [NUM_FLAGS-1:0] stat_q;
   logic [NUM_FLAGS-1:0] flag_set;
   logic                 pin_rise, pin_fall;
   logic                 cnt_wrap, cmp_evt, cap_evt;
   logic                 wr_ctrl, wr_greg, wr_stat, wr_cnt;

   assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
   assign wr_greg = bus_we && (bus_addr == A_GREG);
   assign wr_stat = bus_we && (bus_addr == A_STAT);
   assign wr_cnt  = bus_we && (bus_addr == A_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= IO_OFF;
      else if (wr_ctrl) ctrl_q <= io_mode_e'(bus_wdata[MODE_W-1:0]);
   end

   cct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (tmr_pin_i),
      .rise_o (pin_rise),
      .fall_o (pin_fall)
   );

   cct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_en  (wr_cnt),
      .ld_val (bus_wdata),
      .cnt_o  (cnt_q),
      .wrap_o (cnt_wrap)
   );

   cct_cmp_cap #(.CNT_W(CNT_W)) u_cc (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (ctrl_q),
      .cnt       (cnt_q),
      .gr_we     (wr_greg),
      .gr_wdata  (bus_wdata),
      .rise      (pin_rise),
      .fall      (pin_fall),
      .gr_o      (gr_q),
      .pin_o     (tmr_pin_o),
      .cmp_evt_o (cmp_evt),
      .cap_evt_o (cap_evt)
   );

   always_comb begin
      flag_set         = '0;
      flag_set[ST_CAP] = cap_evt;
      flag_set[ST_CMP] = cmp_evt;
      flag_set[ST_OVF] = cnt_wrap;
   end

   // sticky flags: set wins over a clearing write in the same cycle
   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         logic flag_q;
         logic clr;
         assign clr = wr_stat && !bus_wdata[i] && flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           flag_q <= 1'b0;
            else if (flag_set[i]) flag_q <= 1'b1;
            else if (clr)         flag_q <= 1'b0;
         end
         assign stat_q[i] = flag_q;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL:  bus_rdata[MODE_W-1:0]    = ctrl_q;
         A_GREG:  bus_rdata                = gr_q;
         A_STAT:  bus_rdata[NUM_FLAGS-1:0] = stat_q;
         default: bus_rdata                = cnt_q;
      endcase
   end
endmodule

// File: rtl/cct_chk.sv
module cct_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       mode,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] gr,
   input logic [2:0]       status,
   input logic             pin_o,
   input logic             bus_we,
   input logic [1:0]       bus_addr,
   input logic [CNT_W-1:0] bus_wdata,
   input logic [CNT_W-1:0] bus_rdata,
   input logic             rise,
   input logic             fall
);
   logic match;
   assign match = (mode >= 3'd1) && (mode <= 3'd3) && (cnt == gr);

   // R2
   cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == 2'd3) |=> cnt == $past(cnt) + 1'b1);

   // R2
   ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '1 && !(bus_we && bus_addr == 2'd3)) |=> status[2]);

   // R3
   cmp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> status[1]);

   // R4
   pin_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && mode == 3'd2) |=> pin_o);

   // R4
   pin_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && mode == 3'd1) |=> !pin_o);

   // R4
   pin_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && mode == 3'd3) |=> pin_o != $past(pin_o));

   // R5
   pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 || mode >= 3'd4) |=> pin_o == $past(pin_o));

   // R6
   cap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd5 && rise) |=> (gr == $past(cnt)) && status[0]);

   // R6
   cap_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd6 && fall) |=> (gr == $past(cnt)) && status[0]);

   // R7
   cap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4 && !(bus_we && bus_addr == 2'd1)) |=> gr == $past(gr));

   // R8
   gr_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode >= 3'd5 && !rise && !fall) |=> gr == $past(gr));

   // R11
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[1] && !(bus_we && bus_addr == 2'd2 && !bus_wdata[1])) |=> status[1]);

   // R9
   always_comb begin
      if (rst_n && bus_addr == 2'd0) begin
         ctrl_rsvd_chk: assert (bus_rdata[CNT_W-1:3] == '0);
      end
   end
endmodule

bind cc_timer_channel cct_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (ctrl_q),
   .cnt       (cnt_q),
   .gr        (gr_q),
   .status    (stat_q),
   .pin_o     (tmr_pin_o),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .rise      (pin_rise),
   .fall      (pin_fall)
);

// File: tb/cc_timer_channel_tb.sv
`timescale 1ns/1ps
module cc_timer_channel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        tmr_pin_i = 1'b0;
   logic        tmr_pin_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   cc_timer_channel u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tmr_pin_i(tmr_pin_i), .tmr_pin_o(tmr_pin_o)
   );

   localparam logic [1:0] CTRL = 2'd0, GREG = 2'd1, STAT = 2'd2, CNT = 2'd3;

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(CTRL, v); chk("R1", "mode after reset", v, 16'h0);
      rd(GREG, v); chk("R1", "general after reset", v, 16'h0);
      rd(STAT, v); chk("R1", "status after reset", v, 16'h0);
      chk("R1", "pin after reset", {15'd0, tmr_pin_o}, 16'h0);
   endtask

   task automatic t_counter;
      logic [15:0] v;
      wr(CNT, 16'h1000);
      rd(CNT, v); chk("R2", "counter load", v, 16'h1000);
      waitn(5);
      rd(CNT, v); chk("R2", "counter increment", v, 16'h1005);
   endtask

   task automatic t_overflow;
      logic [15:0] v;
      wr(CNT, 16'hFFFE);
      waitn(1);
      rd(STAT, v); chk("R2", "wrap flag before wrap", v & 16'h4, 16'h0);
      waitn(1);
      rd(STAT, v); chk("R2", "wrap flag on wrap", v & 16'h4, 16'h4);
      rd(CNT, v);  chk("R2", "counter after wrap", v, 16'h0000);
      wr(STAT, 16'hFFFF);
      rd(STAT, v); chk("R10", "write 1 keeps flag", v & 16'h4, 16'h4);
      wr(STAT, 16'hFFFB);
      rd(STAT, v); chk("R10", "write 0 clears flag", v & 16'h4, 16'h0);
   endtask

   // preset counter 3 below 0x8000 and sample just before / after match action
   task automatic run_match(input logic exp_before, input logic exp_after, input string req);
      wr(CNT, 16'h7FFD);
      waitn(3);
      chk(req, "pin before match action", {15'd0, tmr_pin_o}, {15'd0, exp_before});
      waitn(1);
      chk(req, "pin after match action", {15'd0, tmr_pin_o}, {15'd0, exp_after});
   endtask

   task automatic t_cmp_set;
      logic [15:0] v;
      wr(CTRL, 16'h0000);
      wr(GREG, 16'h8000);
      wr(CTRL, 16'h0002);
      rd(STAT, v); chk("R3", "match flag idle", v & 16'h2, 16'h0);
      run_match(1'b0, 1'b1, "R4");
      rd(STAT, v); chk("R3", "match flag set", v & 16'h2, 16'h2);
   endtask

   task automatic t_set_wins;
      logic [15:0] v;
      wr(CNT, 16'h7FFD);
      waitn(3);
      bus_addr = STAT; bus_wdata = 16'hFFFD; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
      rd(STAT, v); chk("R11", "set beats clear", v & 16'h2, 16'h2);
      wr(STAT, 16'hFFFD);
      rd(STAT, v); chk("R10", "match flag cleared", v & 16'h2, 16'h0);
   endtask

   task automatic t_cmp_clr_tgl;
      wr(CTRL, 16'h0001);
      run_match(1'b1, 1'b0, "R4");
      wr(CTRL, 16'h0003);
      run_match(1'b0, 1'b1, "R4");
      run_match(1'b1, 1'b0, "R4");
   endtask

   task automatic t_hold;
      logic [15:0] v;
      wr(CTRL, 16'h0002);
      run_match(1'b0, 1'b1, "R4");
      wr(STAT, 16'h0000);
      wr(CTRL, 16'h0000);
      wr(CNT, 16'h7FFD);
      waitn(6);
      chk("R5", "pin held in mode 0", {15'd0, tmr_pin_o}, 16'h1);
      rd(STAT, v); chk("R5", "no match flag in mode 0", v & 16'h2, 16'h0);
   endtask

   task automatic t_reserved;
      logic [15:0] v;
      wr(CTRL, 16'hFFFC);
      rd(CTRL, v); chk("R9", "reserved bits read 0", v, 16'h0004);
   endtask

   task automatic t_cap_off;
      logic [15:0] v;
      wr(CTRL, 16'h0004);
      wr(GREG, 16'h4321);
      rd(GREG, v); chk("R8", "write allowed in mode 4", v, 16'h4321);
      tmr_pin_i = 1'b1; waitn(5);
      tmr_pin_i = 1'b0; waitn(5);
      rd(GREG, v); chk("R7", "no capture in mode 4", v, 16'h4321);
      rd(STAT, v); chk("R7", "no capture flag in mode 4", v & 16'h1, 16'h0);
      chk("R5", "pin held in capture mode", {15'd0, tmr_pin_o}, 16'h1);
   endtask

   // preset counter, change pin, expect capture of value + 2 (or none)
   task automatic edge_at(input logic [15:0] c, input logic lvl);
      wr(CNT, c);
      tmr_pin_i = lvl;
      waitn(4);
   endtask

   task automatic t_cap_rise;
      logic [15:0] v;
      wr(CTRL, 16'h0005);
      edge_at(16'h2000, 1'b1);
      rd(GREG, v); chk("R6", "rising capture value", v, 16'h2002);
      rd(STAT, v); chk("R6", "capture flag", v & 16'h1, 16'h1);
      wr(GREG, 16'h5555);
      rd(GREG, v); chk("R8", "write ignored in mode 5", v, 16'h2002);
      wr(STAT, 16'hFFFE);
      edge_at(16'h3000, 1'b0);
      rd(GREG, v); chk("R6", "falling ignored in mode 5", v, 16'h2002);
      rd(STAT, v); chk("R6", "no flag on falling in mode 5", v & 16'h1, 16'h0);
   endtask

   task automatic t_cap_fall;
      logic [15:0] v;
      wr(CTRL, 16'h0006);
      edge_at(16'h3100, 1'b1);
      rd(GREG, v); chk("R6", "rising ignored in mode 6", v, 16'h2002);
      edge_at(16'h3200, 1'b0);
      rd(GREG, v); chk("R6", "falling capture value", v, 16'h3202);
      wr(GREG, 16'hAAAA);
      rd(GREG, v); chk("R8", "write ignored in mode 6", v, 16'h3202);
   endtask

   task automatic t_cap_both;
      logic [15:0] v;
      wr(CTRL, 16'h0007);
      edge_at(16'h4000, 1'b1);
      rd(GREG, v); chk("R6", "both-edge rising capture", v, 16'h4002);
      edge_at(16'h5000, 1'b0);
      rd(GREG, v); chk("R6", "both-edge falling capture", v, 16'h5002);
      wr(GREG, 16'h1111);
      rd(GREG, v); chk("R8", "write ignored in mode 7", v, 16'h5002);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_counter();
      t_overflow();
      t_cmp_set();
      t_set_wins();
      t_cmp_clr_tgl();
      t_hold();
      t_reserved();
      t_cap_off();
      t_cap_rise();
      t_cap_fall();
      t_cap_both();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule